// File: doc/BRIEF.md
# Sliding-Window Cumulative Histogram Engine

This block takes one sample per clock and keeps a cumulative histogram of the most recent samples. Bin `j` holds the number of samples in the window whose bin index is at most `j`. Each sample's bin index is the top bits of the sample, and that index is all the block stores. Every accepted sample updates all bins in a single cycle. An increasing step pattern is formed for the entering sample and another for the sample leaving the window. Each bin then counts up, counts down or holds.

The window is `2^n` samples long. Software picks `n` at run time through `win_sel`, and changing it starts a fresh window. A read-out stage uses a bin index to select a count. It gives the probability of being at or below that bin, the complement against the window size, a range difference between two bins, and a fixed-point normalised value. The counters themselves keep full precision.

Top module: `cum_hist_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, every bin count reads zero until a sample is accepted.
- R2: The bin index of a sample is its top `BIN_BITS` bits. Bin `j` counts the in-window samples whose index is less than or equal to `j`, so the top bin counts every in-window sample.
- R3: In a cycle with `in_valid` low, no bin count changes.
- R4: Once the window holds `2^n` samples, each accepted sample evicts the one accepted `2^n` samples earlier, in the same cycle. With `n = 0`, each sample replaces the previous one.
- R5: While fewer than `2^n` samples have been accepted since the last clear, nothing is evicted. The top bin equals the number accepted.
- R6: The effective length code is `win_sel`, with values above `LOGW_MAX` treated as `LOGW_MAX`. A change in the effective code clears all counts and the fill state, and a sample offered in that cycle is discarded. A change in `win_sel` that leaves the effective code the same has no effect.
- R7: Counts are `LOGW_MAX+1` bits wide, so a bin can hold the full window of `2^LOGW_MAX` samples. No bin ever exceeds the window size, and bin counts never decrease with index.
- R8: `below_a` equals the count of bin `idx_a`, and `above_a` equals `2^n` minus that count.
- R9: `span_ab` equals count(`idx_b`) minus count(`idx_a`), modulo `2^(LOGW_MAX+1)`.
- R10: `below_norm` equals count(`idx_a`) shifted left by `LOGW_MAX - n`, so a full window reads `2^LOGW_MAX`. The value has `LOGW_MAX` fraction bits.
- R11: A sample accepted at a clock edge is reflected in the counts and read-outs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | SAMPLE_W | Sample value |
| win_sel | input | SEL_W | Window length code n (window = 2^n) |
| idx_a | input | BIN_BITS | First read-out bin |
| idx_b | input | BIN_BITS | Second read-out bin |
| bin_counts | output | NBINS*CW | All bin counts, bin j at bits j*CW |
| below_a | output | CW | Count of bin idx_a |
| above_a | output | CW | Window size minus count of bin idx_a |
| span_ab | output | CW | Count of idx_b minus count of idx_a |
| below_norm | output | CW | Count of idx_a scaled to LOGW_MAX fraction bits |

## Verification
Several situations are hard to reach from the ports. One is an eviction in which the entering and leaving samples share bins, so that some bins must hold while others move. Another is the circular buffer wrapping at the largest window, where the read point coincides with the write point. The stimulus covers the first with a four-sample window fed from a table, in which the same index both enters and leaves. It covers the second by filling a sixteen-sample window with zero-bin samples and then evicting one. It also drives a length code above the maximum to show that clamping does not clear the window.

// File: rtl/cum_hist_pkg.sv
package cum_hist_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } bin_op_e;
endpackage

// File: rtl/access_pattern.sv
// Step pattern: bin j is enabled when j >= idx.
module access_pattern #(
  parameter int IDX_W = 3,
  localparam int NBINS = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [NBINS-1:0] en
);
  for (genvar j = 0; j < NBINS; j++) begin : g_pat
    localparam logic [IDX_W-1:0] JV = IDX_W'(j);
    assign en[j] = (JV >= idx);
  end
endmodule

// File: rtl/win_fifo.sv
// Circular store of bin indices; read point sits 2^n entries behind write.
module win_fifo #(
  parameter int IDX_W    = 3,
  parameter int LOGW_MAX = 4,
  parameter int SEL_W    = 3,
  localparam int DEPTH   = 1 << LOGW_MAX,
  localparam int CW      = LOGW_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clr,
  input  logic [SEL_W-1:0] win_log,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_old,
  output logic             full,
  output logic [CW-1:0]    fill
);
  logic [IDX_W-1:0]    mem [DEPTH];
  logic [LOGW_MAX-1:0] wp_q, wp_d, rd_ptr;
  logic [CW-1:0]       fill_q, fill_d, win_size;

  assign win_size = CW'(1) << win_log;
  assign full     = (fill_q == win_size);
  assign rd_ptr   = wp_q - LOGW_MAX'(win_size);
  assign idx_old  = mem[rd_ptr];
  assign fill     = fill_q;

  always_comb begin
    fill_d = fill_q;
    wp_d   = wp_q;
    if (clr) begin
      fill_d = '0;
    end else if (push) begin
      wp_d = wp_q + 1'b1;
      if (!full) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      wp_q   <= '0;
    end else begin
      fill_q <= fill_d;
      wp_q   <= wp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= idx_in;
  end

  // R5
  fill_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= win_size);
endmodule

// File: rtl/bin_counter.sv
module bin_counter
  import cum_hist_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  bin_op_e       op,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | (op != OP_HOLD);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (op == OP_INC) cnt_d = cnt_q + 1'b1;
    else if (op == OP_DEC) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op == OP_HOLD) |=> $stable(cnt_q));
endmodule

// File: rtl/prob_readout.sv
module prob_readout #(
  parameter int IDX_W    = 3,
  parameter int LOGW_MAX = 4,
  parameter int SEL_W    = 3,
  localparam int NBINS   = 1 << IDX_W,
  localparam int CW      = LOGW_MAX + 1
) (
  input  logic [NBINS*CW-1:0] counts,
  input  logic [SEL_W-1:0]    win_log,
  input  logic [IDX_W-1:0]    idx_a,
  input  logic [IDX_W-1:0]    idx_b,
  output logic [CW-1:0]       below_a,
  output logic [CW-1:0]       above_a,
  output logic [CW-1:0]       span_ab,
  output logic [CW-1:0]       below_norm
);
  logic [CW-1:0]    cnt_arr [NBINS];
  logic [CW-1:0]    ca, cb, win_size;
  logic [SEL_W-1:0] shamt;

  for (genvar j = 0; j < NBINS; j++) begin : g_unpack
    assign cnt_arr[j] = counts[j*CW +: CW];
  end

  assign ca         = cnt_arr[idx_a];
  assign cb         = cnt_arr[idx_b];
  assign win_size   = CW'(1) << win_log;
  assign shamt      = SEL_W'(LOGW_MAX) - win_log;
  assign below_a    = ca;
  assign above_a    = win_size - ca;
  assign span_ab    = cb - ca;
  assign below_norm = ca << shamt;
endmodule

// File: rtl/cum_hist_engine.sv
module cum_hist_engine
  import cum_hist_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BIN_BITS = 3,
  parameter int LOGW_MAX = 4,
  localparam int NBINS   = 1 << BIN_BITS,
  localparam int CW      = LOGW_MAX + 1,
  localparam int SEL_W   = $clog2(LOGW_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SEL_W-1:0]    win_sel,
  input  logic [BIN_BITS-1:0] idx_a,
  input  logic [BIN_BITS-1:0] idx_b,
  output logic [NBINS*CW-1:0] bin_counts,
  output logic [CW-1:0]       below_a,
  output logic [CW-1:0]       above_a,
  output logic [CW-1:0]       span_ab,
  output logic [CW-1:0]       below_norm
);
  logic [SEL_W-1:0]    win_eff, win_q;
  logic                chg, push, full;
  logic [BIN_BITS-1:0] new_idx, old_idx;
  logic [NBINS-1:0]    new_en, old_en;
  logic [CW-1:0]       fill, win_size;
  logic [CW-1:0]       cnts [NBINS];
  bin_op_e             ops  [NBINS];
  logic                unused_low;

  assign win_eff    = (win_sel > SEL_W'(LOGW_MAX)) ? SEL_W'(LOGW_MAX) : win_sel;
  assign chg        = (win_eff != win_q);
  assign push       = in_valid & ~chg;
  assign new_idx    = in_sample[SAMPLE_W-1 -: BIN_BITS];
  assign unused_low = ^in_sample[SAMPLE_W-BIN_BITS-1:0];
  assign win_size   = CW'(1) << win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_q <= SEL_W'(LOGW_MAX);
    else if (chg) win_q <= win_eff;
  end

  win_fifo #(.IDX_W(BIN_BITS), .LOGW_MAX(LOGW_MAX), .SEL_W(SEL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .clr(chg), .win_log(win_q),
    .idx_in(new_idx), .idx_old(old_idx), .full(full), .fill(fill)
  );

  access_pattern #(.IDX_W(BIN_BITS)) u_pat_new (.idx(new_idx), .en(new_en));
  access_pattern #(.IDX_W(BIN_BITS)) u_pat_old (.idx(old_idx), .en(old_en));

  for (genvar j = 0; j < NBINS; j++) begin : g_bin
    logic inc, dec;
    assign inc    = push & new_en[j] & ~(full & old_en[j]);
    assign dec    = push & full & old_en[j] & ~new_en[j];
    assign ops[j] = inc ? OP_INC : (dec ? OP_DEC : OP_HOLD);

    bin_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(chg), .op(ops[j]), .count(cnts[j])
    );
    assign bin_counts[j*CW +: CW] = cnts[j];

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnts[j] <= win_size);

    if (j > 0) begin : g_mono
      // R7
      monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnts[j-1] <= cnts[j]);
    end
  end

  // R5
  top_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnts[NBINS-1] == fill);

  prob_readout #(.IDX_W(BIN_BITS), .LOGW_MAX(LOGW_MAX), .SEL_W(SEL_W)) u_rd (
    .counts(bin_counts), .win_log(win_q), .idx_a(idx_a), .idx_b(idx_b),
    .below_a(below_a), .above_a(above_a), .span_ab(span_ab),
    .below_norm(below_norm)
  );
endmodule

// File: tb/cum_hist_engine_tb.sv
`timescale 1ns/1ps
module cum_hist_engine_tb;
  localparam int CW = 5;
  localparam int NB = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [7:0]      in_sample;
  logic [2:0]      win_sel, idx_a, idx_b;
  logic [NB*CW-1:0] bin_counts;
  logic [CW-1:0]   below_a, above_a, span_ab, below_norm;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cum_hist_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .win_sel(win_sel), .idx_a(idx_a), .idx_b(idx_b), .bin_counts(bin_counts),
    .below_a(below_a), .above_a(above_a), .span_ab(span_ab),
    .below_norm(below_norm)
  );

  // {valid, bin, expected top count, expected count of bin 3}; window 4
  localparam logic [13:0] VEC [12] = '{
    {1'b1, 3'd2, 5'd1, 5'd1},
    {1'b1, 3'd5, 5'd2, 5'd1},
    {1'b0, 3'd0, 5'd2, 5'd1},
    {1'b1, 3'd7, 5'd3, 5'd1},
    {1'b1, 3'd0, 5'd4, 5'd2},
    {1'b1, 3'd6, 5'd4, 5'd1},
    {1'b1, 3'd3, 5'd4, 5'd2},
    {1'b1, 3'd1, 5'd4, 5'd3},
    {1'b1, 3'd4, 5'd4, 5'd2},
    {1'b1, 3'd3, 5'd4, 5'd3},
    {1'b0, 3'd7, 5'd4, 5'd3},
    {1'b1, 3'd3, 5'd4, 5'd3}
  };

  function automatic int cnt(input int j);
    return int'(bin_counts[j*CW +: CW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] b);
    @(negedge clk);
    in_valid  = v;
    in_sample = {b, 5'b10110};
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    win_sel = 3'd2; idx_a = 3'd3; idx_b = 3'd7;
    repeat (3) @(negedge clk);
    begin
      int s = 0;
      for (int j = 0; j < NB; j++) s += cnt(j);
      chk("R1 counts in reset", s, 0);
    end
    rst_n = 1'b1;
    step(1'b0, 3'd0);
    chk("R1 counts after release", cnt(7) + cnt(0), 0);

    // R2 R3 R4 R5 R8 R9 R10 R11: window of 4 walked from the table
    for (int i = 0; i < 12; i++) begin
      int et, e3;
      et = int'(VEC[i][9:5]);
      e3 = int'(VEC[i][4:0]);
      step(VEC[i][13], VEC[i][12:10]);
      chk("R2/R4/R5 top bin", cnt(7), et);
      chk("R2/R11 bin 3", cnt(3), e3);
      chk("R8 below_a", int'(below_a), e3);
      chk("R8 above_a", int'(above_a), 4 - e3);
      chk("R9 span_ab", int'(span_ab), et - e3);
      chk("R10 below_norm", int'(below_norm), e3 * 4);
    end

    // R6: length change clears and drops the sample offered with it
    win_sel = 3'd3;
    step(1'b1, 3'd0);
    chk("R6 clear on change top", cnt(7), 0);
    chk("R6 dropped sample bin0", cnt(0), 0);
    step(1'b1, 3'd0);
    chk("R6 accept after change", cnt(0), 1);

    // R6: code above maximum clamps to maximum, so no clear
    win_sel = 3'd4;
    step(1'b0, 3'd0);
    win_sel = 3'd7;
    step(1'b1, 3'd0);
    chk("R6 clamp keeps window", cnt(7), 1);

    // R7: full window of 16 at the widest setting
    for (int i = 0; i < 15; i++) step(1'b1, 3'd0);
    chk("R7 full window bin0", cnt(0), 16);
    chk("R5 fill top", cnt(7), 16);
    idx_a = 3'd0;
    step(1'b1, 3'd7);
    chk("R4 wrap eviction bin0", cnt(0), 15);
    chk("R4 wrap top holds", cnt(7), 16);
    chk("R8 above_a wide", int'(above_a), 1);
    chk("R10 norm wide", int'(below_norm), 15);

    // R4: window of one sample
    win_sel = 3'd0;
    step(1'b0, 3'd0);
    step(1'b1, 3'd6);
    chk("R4 win1 bin5 first", cnt(5), 0);
    step(1'b1, 3'd1);
    chk("R4 win1 bin0", cnt(0), 0);
    chk("R4 win1 bin5", cnt(5), 1);
    chk("R4 win1 bin7", cnt(7), 1);
    idx_a = 3'd5;
    #1;
    chk("R10 norm win1", int'(below_norm), 16);
    chk("R8 above win1", int'(above_a), 0);
    idx_a = 3'd7; idx_b = 3'd0;
    #1;
    chk("R9 span wraps", int'(span_ab), 31);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule